// File: doc/BRIEF.md
# Set/Clear Interrupt Event Controller

This block collects interrupt events for a host processor. It holds a 32-bit event register and a 32-bit mask register. Software reaches each one through two write addresses. Writing a one at the "set" address raises the matching bit, and writing a one at the "clear" address drops it. Hardware interrupt source lines also raise event bits, but only on a rising edge, so a source that stays high is reported once. The block drives one level-sensitive interrupt output. That output is high while any event bit is set whose mask bit is also set.

Reading the event register at its set address returns the raw event bits. Reading it at its clear address returns the event bits that pass the mask. A handler can therefore read the masked view, write the same value to the clear address, and see the interrupt drop. When the fatal-error event bit is set, a per-source blocking vector stops new hardware events from the flagged sources. The upper five event bits are reserved.

Top module: `irq_event_ctrl`

## Requirements
- R1: A write to 0x80 sets every event bit whose data bit is one. A write to 0x84 clears every event bit whose data bit is one. A write to 0x88 or 0x8C does the same for the mask bits. Bits written as zero keep their value.
- R2: An event bit (bits 26:0) is set at the first clock edge where its source input is high and was low at the previous edge. While the source stays high, the bit is not set again after software clears it.
- R3: `irq_o` is high exactly when the AND of the event register and the mask register is nonzero.
- R4: A read at 0x80 returns the raw event register. A read at 0x84 returns the event register ANDed with the mask. Reads at 0x88 and 0x8C both return the mask register. Any other address reads as zero.
- R5: Event bits 31:27 always read as zero. Writes and source edges on those bits have no effect.
- R6: While event bit 24 (fatal error) is set, rising edges on sources whose `blk_sel_i` bit is one do not set their event bits. Bit 24 itself is never blocked. Once bit 24 is cleared, edges on those sources set their bits again.
- R7: While `rst_n` is low at a clock edge, the event register, the mask register and the edge history are all cleared.
- R8: Reading 0x84 and writing that value back to 0x84 clears every masked event bit. With no new edge, `irq_o` is then low.
- R9: If a source edge and a clear write for the same bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_i | input | 32 | Hardware interrupt source lines, synchronous to `clk` |
| blk_sel_i | input | 32 | Sources to block while the fatal event bit is set |
| irq_o | output | 1 | Level processor interrupt |

## Verification
Two event sources can act on the same event bit in one cycle: a hardware rising edge and a software clear write. The bench provokes this by driving the clear write to 0x84 and the rising edge on that same source in one bus cycle. It then reads 0x80 and expects the bit to be set. A blocked edge can also arrive in the same cycle that the fatal bit is raised. The bench instead checks the steady state: it raises the fatal bit first, then sends edges on one blocked source and one unblocked source together.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW = 32;
  typedef logic [DW-1:0] word_t;

  // Default register byte offsets
  localparam logic [7:0] OFF_EVT_SET = 8'h80;
  localparam logic [7:0] OFF_EVT_CLR = 8'h84;
  localparam logic [7:0] OFF_MSK_SET = 8'h88;
  localparam logic [7:0] OFF_MSK_CLR = 8'h8C;

  // Ones-set, ones-clear update; a clear that lands on the same bit as a set wins here
  function automatic word_t apply_set_clr(word_t cur, word_t set_v, word_t clr_v);
    return (cur | set_v) & ~clr_v;
  endfunction

  // Rising-edge detect against the registered copy
  function automatic word_t rise_of(word_t now_v, word_t prev_v);
    return now_v & ~prev_v;
  endfunction

  // View of the event register that passes the mask
  function automatic word_t masked_of(word_t evt, word_t msk);
    return evt & msk;
  endfunction
endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t src_i,
  output word_t rise_o
);
  word_t src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_i;
  end

  assign rise_o = rise_of(src_i, src_q);
endmodule

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
  import irq_pkg::*;
#(
  parameter int RSVD_LSB  = 27,
  parameter int FATAL_BIT = 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_we,
  input  logic  clr_we,
  input  word_t wdata,
  input  word_t rise_i,
  input  word_t blk_sel_i,
  output word_t evt_o
);
  word_t evt_q;
  word_t valid_v;
  word_t blkable_v;
  word_t sw_set_v;
  word_t sw_clr_v;
  word_t blocked_v;
  word_t hw_set_v;
  word_t evt_d;
  logic  fatal_act;

  // Which bits exist, and which bits may be blocked
  for (genvar i = 0; i < DW; i++) begin : g_bitcfg
    assign valid_v[i]   = (i < RSVD_LSB);
    assign blkable_v[i] = (i != FATAL_BIT) && blk_sel_i[i];
  end

  assign fatal_act = evt_q[FATAL_BIT];
  assign sw_set_v  = set_we ? (wdata & valid_v) : '0;
  assign sw_clr_v  = clr_we ? (wdata & valid_v) : '0;
  assign blocked_v = fatal_act ? (rise_i & blkable_v) : '0;
  assign hw_set_v  = rise_i & ~blocked_v & valid_v;

  // A hardware edge overrides a clear on the same bit
  assign evt_d = apply_set_clr(evt_q, sw_set_v, sw_clr_v & ~hw_set_v) | hw_set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set_v) |=> ((evt_q & $past(hw_set_v)) == $past(hw_set_v))); // R2
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set_v & sw_clr_v)) |=> ((evt_q & $past(hw_set_v & sw_clr_v)) != 0)); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr_v & ~hw_set_v)) |=> ((evt_q & $past(sw_clr_v & ~hw_set_v)) == 0)); // R1
  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(blocked_v & ~evt_q & ~sw_set_v)) |=> ((evt_q & $past(blocked_v & ~evt_q & ~sw_set_v)) == 0)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != 0 || set_we) |=> ((evt_q & ~valid_v) == 0)); // R5
  AST_RST_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (evt_q == 0)); // R7
endmodule

// File: rtl/irq_msk_reg.sv
module irq_msk_reg
  import irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_we,
  input  logic  clr_we,
  input  word_t wdata,
  output word_t msk_o
);
  word_t msk_q;
  word_t set_v;
  word_t clr_v;

  assign set_v = set_we ? wdata : '0;
  assign clr_v = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) msk_q <= '0;
    else        msk_q <= apply_set_clr(msk_q, set_v, clr_v);
  end

  assign msk_o = msk_q;

  AST_MSK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((msk_q & $past(set_v)) == $past(set_v))); // R1
  AST_MSK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(msk_q)); // R1
  AST_MSK_RST: assert property (@(posedge clk)
    !rst_n |=> (msk_q == 0)); // R7
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] A_EVT_S = OFF_EVT_SET,
  parameter logic [7:0] A_EVT_C = OFF_EVT_CLR,
  parameter logic [7:0] A_MSK_S = OFF_MSK_SET,
  parameter logic [7:0] A_MSK_C = OFF_MSK_CLR
) (
  input  logic [ADDR_W-1:0] addr,
  input  word_t             evt_i,
  input  word_t             msk_i,
  output word_t             rdata
);
  always_comb begin
    unique case (addr)
      ADDR_W'(A_EVT_S): rdata = evt_i;
      ADDR_W'(A_EVT_C): rdata = masked_of(evt_i, msk_i);
      ADDR_W'(A_MSK_S),
      ADDR_W'(A_MSK_C): rdata = msk_i;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RSVD_LSB  = 27,
  parameter int FATAL_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     src_i,
  input  logic [DW-1:0]     blk_sel_i,
  output logic              irq_o
);
  logic  evt_set_we, evt_clr_we, msk_set_we, msk_clr_we;
  word_t rise_w;
  word_t evt_w;
  word_t msk_w;
  word_t rd_w;

  // Bus write decode
  assign evt_set_we = wr_en && (addr == ADDR_W'(OFF_EVT_SET));
  assign evt_clr_we = wr_en && (addr == ADDR_W'(OFF_EVT_CLR));
  assign msk_set_we = wr_en && (addr == ADDR_W'(OFF_MSK_SET));
  assign msk_clr_we = wr_en && (addr == ADDR_W'(OFF_MSK_CLR));

  irq_src_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .rise_o (rise_w)
  );

  irq_evt_reg #(.RSVD_LSB(RSVD_LSB), .FATAL_BIT(FATAL_BIT)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_we    (evt_set_we),
    .clr_we    (evt_clr_we),
    .wdata     (wdata),
    .rise_i    (rise_w),
    .blk_sel_i (blk_sel_i),
    .evt_o     (evt_w)
  );

  irq_msk_reg u_msk (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (msk_set_we),
    .clr_we (msk_clr_we),
    .wdata  (wdata),
    .msk_o  (msk_w)
  );

  irq_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr  (addr),
    .evt_i (evt_w),
    .msk_i (msk_w),
    .rdata (rd_w)
  );

  assign rdata = rd_w;
  assign irq_o = |masked_of(evt_w, msk_w);

  AST_IRQ_VS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(OFF_EVT_CLR)) |-> (irq_o == (rdata != 0))); // R3
  AST_WRITEBACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr_we && wdata == masked_of(evt_w, msk_w) && rise_w == 0 && !msk_set_we) |=> !irq_o); // R8
endmodule

// File: tb/irq_event_ctrl_bench.sv
module irq_event_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src_i = '0;
  logic [31:0] blk_sel_i = '0;
  logic        irq_o;

  always #10 clk = ~clk; // 50 MHz

  irq_event_ctrl u_irq_event_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_i(src_i), .blk_sel_i(blk_sel_i), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // Requirement-level model
  logic [31:0] evt_m = '0, msk_m = '0, src_m = '0, blk_m = '0;
  localparam logic [31:0] LIVE  = 32'h07FF_FFFF; // R5: bits 26:0 exist
  localparam logic [31:0] FATAL = 32'h0100_0000; // R6: bit 24

  function automatic logic [31:0] expect_rd(logic [7:0] a);
    case (a)
      8'h80:        return evt_m;
      8'h84:        return evt_m & msk_m;
      8'h88, 8'h8C: return msk_m;
      default:      return 32'h0;
    endcase
  endfunction

  task automatic step(bit we, logic [7:0] a, logic [31:0] d, logic [31:0] s, logic [31:0] b);
    logic [31:0] edges, hw, clr;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; src_i = s; blk_sel_i = b;
    edges = s & ~src_m;
    if (evt_m & FATAL) edges = edges & ~(b & ~FATAL);   // R6
    hw = edges & LIVE;
    clr = 32'h0;
    if (we && a == 8'h80) evt_m = evt_m | (d & LIVE);
    if (we && a == 8'h84) clr = d & LIVE;
    evt_m = (evt_m & ~(clr & ~hw)) | hw;                  // R9
    if (we && a == 8'h88) msk_m = msk_m | d;
    if (we && a == 8'h8C) msk_m = msk_m & ~d;
    src_m = s; blk_m = b;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, src_m, blk_m);
  endtask

  task automatic drive_src(logic [31:0] s);
    step(1'b0, 8'h00, 32'h0, s, blk_m);
  endtask

  // Read: push expected rdata and expected irq for the cycle being driven
  task automatic rd(logic [7:0] a, string req);
    item_t it;
    logic [31:0] e_rd;
    logic        e_irq;
    e_rd  = expect_rd(a);
    e_irq = |(evt_m & msk_m);
    step(1'b0, a, 32'h0, src_m, blk_m);
    it.is_irq = 1'b0; it.exp = e_rd; it.req = req; q.push_back(it);
    it.is_irq = 1'b1; it.exp = {31'h0, e_irq}; it.req = "R3"; q.push_back(it);
  endtask

  // Monitor: compares once outputs have settled after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (it.is_irq) begin
          if (irq_o !== it.exp[0]) begin
            n_err++;
            $display("FAIL %s: irq_o=%b expected %b", it.req, irq_o, it.exp[0]);
          end
        end else if (rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: rdata=%h expected %h (addr %h)", it.req, rdata, it.exp, addr);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    rd(8'h80, "R7"); rd(8'h88, "R7");
    // R5 / R1: set everything, reserved stay zero
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, "R5"); rd(8'h84, "R4");
    // R1 / R4 mask access
    wr(8'h88, 32'h0000_00F0);
    rd(8'h88, "R4"); rd(8'h8C, "R4"); rd(8'h84, "R3"); rd(8'h90, "R4");
    // R8: write back masked value
    wr(8'h84, 32'h0000_00F0);
    rd(8'h80, "R8");
    // R1: zero writes keep bits
    wr(8'h80, 32'h0); rd(8'h80, "R1");
    wr(8'h84, 32'h0); rd(8'h80, "R1");
    wr(8'h84, 32'hFFFF_FFFF); rd(8'h80, "R1");
    // R2: edge, then held level
    drive_src(32'h0000_0020); rd(8'h80, "R2");
    wr(8'h84, 32'h0000_0020); rd(8'h80, "R2");
    rd(8'h80, "R2");
    drive_src(32'h0); drive_src(32'h0000_0020); rd(8'h84, "R2");
    // R9: edge and clear on bit 6 together
    step(1'b1, 8'h84, 32'h0000_0040, 32'h0000_0060, 32'h0);
    rd(8'h80, "R9");
    // R5: edge on reserved bit 31
    drive_src(32'h8000_0060); rd(8'h80, "R5");
    // R6: blocking while fatal bit is set
    wr(8'h84, 32'hFFFF_FFFF);
    step(1'b1, 8'h80, FATAL, src_m, 32'h0100_0100);
    drive_src(src_m | 32'h0000_0300); rd(8'h80, "R6");
    wr(8'h84, FATAL); drive_src(src_m & ~32'h0000_0100);
    drive_src(src_m | 32'h0000_0100); rd(8'h80, "R6");
    // R1: mask clear
    wr(8'h8C, 32'h0000_00F0); rd(8'h88, "R1"); rd(8'h84, "R3");
    // R8: unmask, handle and write back
    wr(8'h88, 32'h0000_0300); rd(8'h84, "R3");
    wr(8'h84, 32'h0000_0300); rd(8'h84, "R8");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule